// File: doc/BRIEF.md
# Motor Bridge Fault Supervisor

This block sits between the digitised protection flags of an H-bridge motor stage and the bridge and charge-pump enables. It takes four synchronous flags: supply undervoltage, overcurrent comparator, temperature warning and temperature shutdown. From these it decides when the bridge must be forced off, when the charge pump must stop, and when the shared active-low fault line must be pulled down.

Each fault class has its own recovery rule. Undervoltage stops everything but reports nothing. An overcurrent must persist through a deglitch window before it trips. A trip then holds the bridge off for a fixed retry period, after which the bridge follows its commands again with the fault released. The temperature warning only reports. Temperature shutdown stops the bridge and the pump and reports, then recovers by itself when its flag clears. A sleep request clears all fault state.

The fault output is an output enable for a pull-down transistor, so several instances can share one line with a single pull-up. Both timing windows are parameters counted in clock cycles.

Top module: `motsup_top`

## Requirements
- R1: After reset, with sleep low and every flag low, bridgeOff, pumpOff and faultPull are all 0.
- R2: An overcurrent trip requires ocFlag high at DEG_CYCLES consecutive rising clock edges. A shorter run, or a run broken by a low sample, leaves every output unchanged.
- R3: On a trip, bridgeOff and faultPull go to 1 right after the edge that completes the deglitch run and stay at 1 for exactly RETRY_CYCLES cycles. pumpOff does not change.
- R4: When the retry period ends, bridgeOff and faultPull return to 0. If ocFlag is still high, a fresh deglitch run starts, so the trip and release cycle repeats.
- R5: uvFlag forces bridgeOff and pumpOff to 1 in the same cycle and never sets faultPull on its own. Both outputs return to 0 in the cycle uvFlag clears.
- R6: Undervoltage has priority over overcurrent. Any edge at which uvFlag is high clears the deglitch count and ends a retry hold, so after uvFlag clears the bridge is enabled at once and a new trip needs a full deglitch run.
- R7: otWarnFlag sets faultPull to 1 in the same cycle without touching bridgeOff or pumpOff, and releases it when the flag clears.
- R8: otShutFlag forces bridgeOff, pumpOff and faultPull to 1 in the same cycle, and all three return to 0 when it clears. Overcurrent samples taken while it is high do not count toward a trip.
- R9: While sleepReq is 1, bridgeOff and pumpOff are 1 and faultPull is 0. Every edge with sleepReq high clears the deglitch count and any retry hold.
- R10: faultPull is an open-drain enable. A line driven low by any of several instances and otherwise pulled high shows 0 exactly when at least one instance has faultPull at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleepReq | input | 1 | 1 puts the supervisor in sleep and clears its state |
| uvFlag | input | 1 | Supply undervoltage flag, hysteresis already applied |
| ocFlag | input | 1 | Raw overcurrent comparator flag |
| otWarnFlag | input | 1 | Die temperature warning flag |
| otShutFlag | input | 1 | Die temperature shutdown flag |
| bridgeOff | output | 1 | 1 forces every bridge FET off |
| pumpOff | output | 1 | 1 stops the charge pump |
| faultPull | output | 1 | 1 enables the pull-down on the shared fault line |

## Verification
Assertions check these properties on every cycle: the counters stay inside their windows, a trip is always preceded by a sampled overcurrent, undervoltage has cleared the retry hold one edge later, the pump never stops while the bridge runs, and sleep and the warning drive the fault line as required. Other behaviour can only be shown by the bench's scenarios, which compare against a cycle model: the exact trip and hold lengths, rejection of short or broken glitches, the repeating retry under a stuck short, recovery after undervoltage, and the wired-OR line shared by two instances.

// File: rtl/motsup_pkg.sv
package motsup_pkg;

  // Strobes the control FSM sends to the counter datapath
  typedef struct packed {
    logic clrDeg;
    logic incDeg;
    logic clrRetry;
    logic incRetry;
  } supStrobe_t;

  typedef enum logic {
    ST_WATCH = 1'b0,
    ST_HOLD  = 1'b1
  } ocState_t;

endpackage

// File: rtl/motsup_datapath.sv
module motsup_datapath
  import motsup_pkg::*;
#(
  parameter int DEG_CYCLES   = 600,
  parameter int RETRY_CYCLES = 240000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  supStrobe_t strobe,
  output logic       degHit,
  output logic       retryHit
);

  localparam int DEG_W   = (DEG_CYCLES   > 1) ? $clog2(DEG_CYCLES)   : 1;
  localparam int RETRY_W = (RETRY_CYCLES > 1) ? $clog2(RETRY_CYCLES) : 1;
  localparam logic [DEG_W-1:0]   DEG_LAST   = DEG_W'(DEG_CYCLES - 1);
  localparam logic [RETRY_W-1:0] RETRY_LAST = RETRY_W'(RETRY_CYCLES - 1);

  logic [DEG_W-1:0]   degCnt;
  logic [RETRY_W-1:0] retryCnt;

  // Deglitch run-length counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             degCnt <= '0;
    else if (strobe.clrDeg) degCnt <= '0;
    else if (strobe.incDeg) degCnt <= degCnt + 1'b1;
  end

  // Retry hold timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               retryCnt <= '0;
    else if (strobe.clrRetry) retryCnt <= '0;
    else if (strobe.incRetry) retryCnt <= retryCnt + 1'b1;
  end

  assign degHit   = (degCnt == DEG_LAST);
  assign retryHit = (retryCnt == RETRY_LAST);

  assert_deg_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    degCnt <= DEG_LAST);

  assert_retry_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    retryCnt <= RETRY_LAST);

endmodule

// File: rtl/motsup_ctrl.sv
module motsup_ctrl
  import motsup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleepReq,
  input  logic       uvFlag,
  input  logic       ocFlag,
  input  logic       otShutFlag,
  input  logic       degHit,
  input  logic       retryHit,
  output supStrobe_t strobe,
  output logic       ocHold
);

  ocState_t state, nextState;
  logic     blocked;

  assign blocked = sleepReq | uvFlag;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_WATCH: begin
        strobe.incDeg   = ocFlag & ~blocked & ~otShutFlag;
        strobe.clrDeg   = ~strobe.incDeg | degHit;
        strobe.clrRetry = 1'b1;
        if (strobe.incDeg && degHit) nextState = ST_HOLD;
      end
      ST_HOLD: begin
        strobe.clrDeg   = 1'b1;
        strobe.incRetry = ~blocked;
        strobe.clrRetry = blocked | retryHit;
        if (blocked || retryHit) nextState = ST_WATCH;
      end
      default: nextState = ST_WATCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_WATCH;
    else        state <= nextState;
  end

  assign ocHold = (state == ST_HOLD);

  assert_trip_after_oc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ocHold) |-> $past(ocFlag));

  assert_uv_ends_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(uvFlag) && uvFlag) |-> !ocHold);

  assert_sleep_ends_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleepReq |=> !ocHold);

endmodule

// File: rtl/motsup_top.sv
module motsup_top
  import motsup_pkg::*;
#(
  parameter int DEG_CYCLES   = 600,
  parameter int RETRY_CYCLES = 240000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleepReq,
  input  logic uvFlag,
  input  logic ocFlag,
  input  logic otWarnFlag,
  input  logic otShutFlag,
  output logic bridgeOff,
  output logic pumpOff,
  output logic faultPull
);

  supStrobe_t strobe;
  logic       degHit;
  logic       retryHit;
  logic       ocHold;

  motsup_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleepReq   (sleepReq),
    .uvFlag     (uvFlag),
    .ocFlag     (ocFlag),
    .otShutFlag (otShutFlag),
    .degHit     (degHit),
    .retryHit   (retryHit),
    .strobe     (strobe),
    .ocHold     (ocHold)
  );

  motsup_datapath #(
    .DEG_CYCLES   (DEG_CYCLES),
    .RETRY_CYCLES (RETRY_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .degHit   (degHit),
    .retryHit (retryHit)
  );

  // Sleep and undervoltage stop everything silently; shutdown stops and reports
  assign pumpOff   = sleepReq | uvFlag | otShutFlag;
  assign bridgeOff = pumpOff | ocHold;
  assign faultPull = ~sleepReq & (otWarnFlag | otShutFlag | (ocHold & ~uvFlag));

  assert_pump_needs_bridge_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pumpOff |-> bridgeOff);

  assert_warn_reports_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (otWarnFlag && !sleepReq) |-> faultPull);

  assert_sleep_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleepReq |-> (!faultPull && bridgeOff));

  assert_uv_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (uvFlag && !otWarnFlag && !otShutFlag) |-> !faultPull);

endmodule

// File: tb/motsup_top_tb.sv
`timescale 1ns/1ps
module motsup_top_tb;

  localparam int DEG   = 5;
  localparam int RETRY = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleepReq = 1'b0, uvFlag = 1'b0, ocFlag = 1'b0, otWarnFlag = 1'b0, otShutFlag = 1'b0;
  logic warn2 = 1'b0;
  logic bridgeOff, pumpOff, faultPull;
  logic bOff2, pOff2, fPull2;
  logic faultLine;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // model state
  bit mHold = 1'b0;
  int mRun = 0;
  int mLeft = 0;

  always #2.5 clk = ~clk;

  motsup_top #(.DEG_CYCLES(DEG), .RETRY_CYCLES(RETRY)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleepReq(sleepReq), .uvFlag(uvFlag), .ocFlag(ocFlag),
    .otWarnFlag(otWarnFlag), .otShutFlag(otShutFlag),
    .bridgeOff(bridgeOff), .pumpOff(pumpOff), .faultPull(faultPull));

  motsup_top #(.DEG_CYCLES(DEG), .RETRY_CYCLES(RETRY)) u_dut2 (
    .clk(clk), .rst_n(rst_n), .sleepReq(1'b0), .uvFlag(1'b0), .ocFlag(1'b0),
    .otWarnFlag(warn2), .otShutFlag(1'b0),
    .bridgeOff(bOff2), .pumpOff(pOff2), .faultPull(fPull2));

  // open-drain line with pull-up
  assign faultLine = ~(faultPull | fPull2);

  function automatic logic [3:0] expected();
    logic eb, ep, ef, el;
    ep = sleepReq | uvFlag | otShutFlag;
    eb = ep | mHold;
    ef = !sleepReq && (otWarnFlag || otShutFlag || (mHold && !uvFlag));
    el = !(ef || warn2);
    return {eb, ep, ef, el};
  endfunction

  task automatic modelEdge();
    if (sleepReq || uvFlag) begin
      mHold = 1'b0; mRun = 0; mLeft = 0;
    end else if (mHold) begin
      mRun = 0;
      mLeft--;
      if (mLeft == 0) mHold = 1'b0;
    end else if (ocFlag && !otShutFlag) begin
      mRun++;
      if (mRun == DEG) begin mHold = 1'b1; mLeft = RETRY; mRun = 0; end
    end else begin
      mRun = 0;
    end
  endtask

  // called at a negedge after inputs are set; checks, then advances one cycle
  task automatic step(input string tag);
    logic [3:0] exp, act;
    #1;
    exp = expected();
    act = {bridgeOff, pumpOff, faultPull, faultLine};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s t=%0t {bridgeOff,pumpOff,faultPull,line} actual=%b expected=%b",
               tag, $time, act, exp);
    end
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  task automatic setIn(input logic s, input logic u, input logic o, input logic w, input logic t);
    sleepReq = s; uvFlag = u; ocFlag = o; otWarnFlag = w; otShutFlag = t;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    setIn(0,0,0,0,0);
    repeat (3) step("R1");

    // R2: short and broken glitches are rejected
    ocFlag = 1'b1; repeat (DEG-1) step("R2");
    ocFlag = 1'b0; step("R2");
    ocFlag = 1'b1; repeat (DEG-2) step("R2");
    ocFlag = 1'b0; repeat (2) step("R2");

    // R3 and R4: stuck short, trip, hold, retry and repeat
    ocFlag = 1'b1;
    repeat (DEG) step("R3");
    repeat (RETRY) step("R3");
    repeat (DEG) step("R4");
    repeat (RETRY) step("R4");
    ocFlag = 1'b0;
    repeat (4) step("R4");

    // R6: undervoltage ends a hold and clears the deglitch run
    ocFlag = 1'b1; repeat (DEG + 3) step("R6");
    uvFlag = 1'b1; repeat (3) step("R6");
    uvFlag = 1'b0; repeat (DEG - 1) step("R6");
    ocFlag = 1'b0; repeat (2) step("R6");
    ocFlag = 1'b1; repeat (DEG - 2) step("R6");
    uvFlag = 1'b1; step("R6");
    uvFlag = 1'b0; repeat (DEG - 1) step("R6");
    ocFlag = 1'b0; step("R6");

    // R5: silent undervoltage
    uvFlag = 1'b1; repeat (4) step("R5");
    uvFlag = 1'b0; repeat (2) step("R5");

    // R7: warning only reports
    otWarnFlag = 1'b1; repeat (4) step("R7");
    otWarnFlag = 1'b0; repeat (2) step("R7");

    // R8: shutdown stops and reports; overcurrent ignored meanwhile
    otShutFlag = 1'b1; ocFlag = 1'b1; repeat (DEG + 2) step("R8");
    otShutFlag = 1'b0; ocFlag = 1'b0; repeat (3) step("R8");

    // R9: sleep during a hold clears it and releases the line
    ocFlag = 1'b1; repeat (DEG + 2) step("R9");
    sleepReq = 1'b1; otWarnFlag = 1'b1; repeat (3) step("R9");
    sleepReq = 1'b0; otWarnFlag = 1'b0; ocFlag = 1'b0; repeat (3) step("R9");

    // R10: wired-OR fault line across two instances
    warn2 = 1'b1; repeat (3) step("R10");
    otWarnFlag = 1'b1; repeat (2) step("R10");
    warn2 = 1'b0; repeat (2) step("R10");
    otWarnFlag = 1'b0; repeat (2) step("R10");

    // constrained random mix, biased toward long overcurrent runs
    for (int i = 0; i < 4000; i++) begin
      sleepReq   = ($urandom_range(99) < 2);
      uvFlag     = ($urandom_range(99) < 3);
      otShutFlag = ($urandom_range(99) < 3);
      otWarnFlag = ($urandom_range(99) < 8);
      warn2      = ($urandom_range(99) < 5);
      if ($urandom_range(99) < 12) ocFlag = ~ocFlag;
      step("R2/R3/R4 random");
    end

    setIn(0,0,0,0,0); warn2 = 1'b0;
    repeat (RETRY + DEG) step("R4");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule